// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block sits behind the registered control pins of a flow-through synchronous burst SRAM and decides what each clock edge does. It samples two address strobes (a processor strobe and a controller strobe), three chip enables, a burst-advance pin, a global write, a byte-write gate and one write enable per byte lane. From these it works out the command for that edge: load a new address, advance the burst, hold the address, or deselect. It also builds the per-lane write mask and the read-data output enable. The block contains its own storage array, sized by a parameter and split into two 9-bit lanes. The ninth bit of each lane is that lane's parity bit and is always written together with the lane's data.

Reads are flow-through. The word at the address taken at an edge appears on `rdata` within the following clock period, with no output register in the path. A sleep input gates every other input and forces the output enable low. The array keeps its contents while asleep. The pins carry no data stream with flow control: each edge performs exactly one operation, so there is no valid/ready handshake and no back-pressure. The output enable is the only qualifier on `rdata`.

Top module: `sbsram_ctl`

## Requirements
- R1: The reset is synchronous and active high. After reset the controller is deselected and `rdata_en` is low.
- R2: Processor strobe low with `ce_n` low loads `addr` (if both secondary enables pass) and starts a read. On that edge the write inputs and the controller strobe have no effect, and `wr_mask` is 0.
- R3: Processor strobe low with `ce_n` high is ignored entirely. The edge then acts as though that strobe were high.
- R4: Controller strobe low with `ce_n` low loads `addr` and performs the write selected by the write inputs, or a read if none is selected. Controller strobe low with `ce_n` high deselects the controller.
- R5: On a strobe edge with `ce_n` low, the controller deselects if `ce2` is low or `ce2_n` is high. On edges without a strobe, the chip enables are ignored.
- R6: The write mask is decoded as follows. `gw_n` low writes both lanes. Otherwise `bwe_n` low writes every lane whose `bw_n` bit is low. Lane 0 is `wdata[8:0]` and lane 1 is `wdata[17:9]`, with bit 8 of each lane being its parity bit. With no lane selected, the edge is a read.
- R7: After a processor-strobe load, a later edge with no strobe, `adv_n` high and write inputs asserted writes to the loaded address.
- R8: An edge with `adv_n` low and no strobe, while selected, advances the two low address bits by a burst counter k = 1, 2, 3, 0, and so on. With `linear_mode` = 1 the low bits are (start + k) mod 4. With `linear_mode` = 0 they are start XOR k. The upper address bits never change during a burst.
- R9: An edge with no strobe and `adv_n` high keeps the current address (a wait state). A strobe on any edge interrupts a running burst. At most one of `cmd_load`, `cmd_adv` and `cmd_hold` is high at a time.
- R10: `rdata_en` is high exactly when the controller is selected, in read mode, `oe_n` is low and `sleep` is low. After a deselect or a write it stays low, including through wait-state read edges, until a strobe or advance edge performs a read.
- R11: While `sleep` is high, and on the first edge after it falls, all other inputs are ignored: no writes and no commands. The controller deselects. Array contents are kept.
- R12: Reads are flow-through. In the cycle after a read edge, `rdata` equals the array word at `burst_addr`, including data written by earlier edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register samples on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sleep | input | 1 | Sleep request, active high; gates all other inputs |
| strobe_p_n | input | 1 | Processor address strobe, active low |
| strobe_c_n | input | 1 | Controller address strobe, active low |
| ce_n | input | 1 | Primary chip enable, active low |
| ce2_n | input | 1 | Secondary chip enable, active low |
| ce2 | input | 1 | Secondary chip enable, active high |
| adv_n | input | 1 | Burst advance, active low; high requests a wait state |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write gate, active low |
| bw_n | input | 2 | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low, acts without a clock |
| linear_mode | input | 1 | 1 selects linear burst order, 0 selects interleaved order |
| addr | input | 8 | External word address |
| wdata | input | 18 | Write data, two 9-bit lanes |
| rdata | output | 18 | Flow-through read data |
| rdata_en | output | 1 | Read-data drive enable |
| cmd_load | output | 1 | This edge loads the external address |
| cmd_adv | output | 1 | This edge advances the burst |
| cmd_hold | output | 1 | This edge holds the address |
| wr_mask | output | 2 | Lanes written on this edge |
| burst_addr | output | 8 | Address currently presented to the array |

## Verification
The bench builds the block with its default parameters: a depth of 256 words with an 8-bit address and two 9-bit lanes. At that size it can fill every word through controller-strobe global writes before any read, so every read data value is known and compared exactly. The small depth also puts bursts that start at each low-address offset, in both orders, within a few cycles of each other. This exposes wrap-around in both the linear and interleaved orders on words next to each other.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  typedef struct packed {
    logic load;
    logic adv;
    logic hold;
    logic desel;
  } edge_cmd_t;
endpackage

// File: rtl/sbsram_decode.sv
module sbsram_decode #(
  parameter int LANES = 2
) (
  input  logic                   gated,
  input  logic                   active,
  input  logic                   sp_n,
  input  logic                   sc_n,
  input  logic                   ce_n,
  input  logic                   ce2_n,
  input  logic                   ce2,
  input  logic                   adv_n,
  input  logic                   gw_n,
  input  logic                   bwe_n,
  input  logic [LANES-1:0]       bw_n,
  output sbsram_pkg::edge_cmd_t  cmd,
  output logic [LANES-1:0]       mask
);
  logic [LANES-1:0] lane_req;
  logic             strobe, sel_ok;

  always_comb begin
    lane_req = gw_n ? (bwe_n ? '0 : ~bw_n) : '1;
    // the processor strobe only counts with the primary enable low
    strobe   = !sc_n || (!sp_n && !ce_n);
    sel_ok   = !ce_n && ce2 && !ce2_n;
    cmd      = '0;
    mask     = '0;
    if (!gated) begin
      if (strobe) begin
        if (sel_ok) begin
          cmd.load = 1'b1;
          mask     = (!sp_n) ? '0 : lane_req;
        end else begin
          cmd.desel = 1'b1;
        end
      end else if (active) begin
        cmd.adv  = !adv_n;
        cmd.hold = adv_n;
        mask     = lane_req;
      end
    end
  end
endmodule

// File: rtl/sbsram_burst.sv
module sbsram_burst #(
  parameter int AW = 8,
  parameter int BB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          adv,
  input  logic          linear,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] tgt,
  output logic [AW-1:0] cur
);
  logic [BB-1:0] base_lo_q, cnt_q, cnt_nx, lo_nx;
  logic [AW-1:0] cur_q;

  always_comb begin
    cnt_nx = cnt_q + 1'b1;
    lo_nx  = linear ? (base_lo_q + cnt_nx) : (base_lo_q ^ cnt_nx);
    if (load)     tgt = addr_in;
    else if (adv) tgt = {cur_q[AW-1:BB], lo_nx};
    else          tgt = cur_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q     <= '0;
      cnt_q     <= '0;
      base_lo_q <= '0;
    end else begin
      cur_q <= tgt;
      if (load) begin
        base_lo_q <= addr_in[BB-1:0];
        cnt_q     <= '0;
      end else if (adv) begin
        cnt_q <= cnt_nx;
      end
    end
  end

  assign cur = cur_q;

  AST_WAIT_KEEPS_ADDR: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv) |=> $stable(cur_q)); // R9
  AST_BURST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
    (adv && !load) |=> (cur_q[AW-1:BB] == $past(cur_q[AW-1:BB]))); // R8
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int AW     = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [AW-1:0]           waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [AW-1:0]           raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end
    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/sbsram_ctl.sv
module sbsram_ctl #(
  parameter int AW         = 8,
  parameter int LANES      = 2,
  parameter int LANE_W     = 9,
  parameter int BURST_BITS = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sleep,
  input  logic                    strobe_p_n,
  input  logic                    strobe_c_n,
  input  logic                    ce_n,
  input  logic                    ce2_n,
  input  logic                    ce2,
  input  logic                    adv_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    oe_n,
  input  logic                    linear_mode,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_en,
  output logic                    cmd_load,
  output logic                    cmd_adv,
  output logic                    cmd_hold,
  output logic [LANES-1:0]        wr_mask,
  output logic [AW-1:0]           burst_addr
);
  sbsram_pkg::edge_cmd_t cmd;
  logic          sleep_q, gated, active_q, rd_q;
  logic [AW-1:0] tgt;

  assign gated = sleep | sleep_q;

  sbsram_decode #(.LANES(LANES)) u_dec (
    .gated(gated), .active(active_q), .sp_n(strobe_p_n), .sc_n(strobe_c_n),
    .ce_n(ce_n), .ce2_n(ce2_n), .ce2(ce2), .adv_n(adv_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .cmd(cmd), .mask(wr_mask));

  sbsram_burst #(.AW(AW), .BB(BURST_BITS)) u_burst (
    .clk(clk), .rst(rst), .load(cmd.load), .adv(cmd.adv), .linear(linear_mode),
    .addr_in(addr), .tgt(tgt), .cur(burst_addr));

  sbsram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk(clk), .we(wr_mask), .waddr(tgt), .wdata(wdata),
    .raddr(burst_addr), .rdata(rdata));

  always_ff @(posedge clk) begin
    if (rst) begin
      sleep_q  <= 1'b0;
      active_q <= 1'b0;
      rd_q     <= 1'b0;
    end else begin
      sleep_q <= sleep;
      if (gated || cmd.desel) begin
        active_q <= 1'b0;
        rd_q     <= 1'b0;
      end else if (cmd.load || cmd.adv) begin
        active_q <= 1'b1;
        rd_q     <= (wr_mask == '0);
      end else if (cmd.hold && wr_mask != '0) begin
        rd_q <= 1'b0;
      end
    end
  end

  assign cmd_load = cmd.load;
  assign cmd_adv  = cmd.adv;
  assign cmd_hold = cmd.hold;
  assign rdata_en = active_q & rd_q & ~oe_n & ~sleep;

  AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_load, cmd_adv, cmd_hold})); // R9
  AST_PSTROBE_READONLY: assert property (@(posedge clk) disable iff (rst)
    (!gated && !strobe_p_n && !ce_n) |-> (wr_mask == '0)); // R2
  AST_SLEEP_DESELECTS: assert property (@(posedge clk) disable iff (rst)
    sleep |=> !active_q); // R11
  AST_WRITE_BLANKS_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    (wr_mask != '0) |=> !rdata_en); // R10
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!gated && !strobe_c_n && ce_n) |=> !rdata_en); // R4
endmodule

// File: tb/sbsram_ctl_test.sv
module sbsram_ctl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, sleep = 1'b0;
  logic sp_n = 1, sc_n = 1, ce_n = 0, ce2_n = 0, ce2 = 1, adv_n = 1;
  logic gw_n = 1, bwe_n = 1, oe_n = 0, lin = 1;
  logic [1:0]  bw_n = 2'b11;
  logic [7:0]  addr = '0;
  logic [17:0] wdata = '0;
  logic [17:0] rdata;
  logic        rdata_en, cmd_load, cmd_adv, cmd_hold;
  logic [1:0]  wr_mask;
  logic [7:0]  burst_addr;

  int total = 0, bad = 0;
  bit done = 0;
  string tag = "R1";

  bit m_act = 0, m_rd = 0, m_sq = 0;
  int m_cur = 0, m_blo = 0, m_cnt = 0;
  logic [17:0] mm [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  sbsram_ctl uut (
    .clk(clk), .rst(rst), .sleep(sleep), .strobe_p_n(sp_n), .strobe_c_n(sc_n),
    .ce_n(ce_n), .ce2_n(ce2_n), .ce2(ce2), .adv_n(adv_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .linear_mode(lin), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_en(rdata_en), .cmd_load(cmd_load),
    .cmd_adv(cmd_adv), .cmd_hold(cmd_hold), .wr_mask(wr_mask),
    .burst_addr(burst_addr));

  task automatic chk(string what, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    sleep = 0; sp_n = 1; sc_n = 1; ce_n = 0; ce2_n = 0; ce2 = 1;
    adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = 2'b11; oe_n = 0;
  endtask

  // one clock: decode checks, edge, model update, registered checks
  task automatic cyc();
    bit g, strobe, ok, e_load, e_adv, e_hold, e_des;
    int req, e_mask, t, nc, lo;
    #1;
    g      = sleep || m_sq;
    req    = !gw_n ? 3 : (!bwe_n ? (~bw_n) & 3 : 0);
    strobe = !sc_n || (!sp_n && !ce_n);
    ok     = !ce_n && ce2 && !ce2_n;
    e_load = 0; e_adv = 0; e_hold = 0; e_des = 0; e_mask = 0;
    if (!g) begin
      if (strobe) begin
        if (ok) begin e_load = 1; e_mask = !sp_n ? 0 : req; end
        else e_des = 1;
      end else if (m_act) begin
        e_adv = !adv_n; e_hold = adv_n; e_mask = req;
      end
    end
    chk("cmd_load", cmd_load, e_load);
    chk("cmd_adv", cmd_adv, e_adv);
    chk("cmd_hold", cmd_hold, e_hold);
    chk("wr_mask", wr_mask, e_mask);
    @(posedge clk);
    t = m_cur;
    if (e_load) t = addr;
    else if (e_adv) begin
      nc = (m_cnt + 1) & 3;
      lo = lin ? (m_blo + nc) & 3 : (m_blo ^ nc);
      t = (m_cur & ~3) | lo;
    end
    if (e_mask[0]) mm[t][8:0]  = wdata[8:0];
    if (e_mask[1]) mm[t][17:9] = wdata[17:9];
    if (g || e_des) begin m_act = 0; m_rd = 0; end
    else if (e_load || e_adv) begin
      m_act = 1; m_rd = (e_mask == 0);
      if (e_load) begin m_blo = addr & 3; m_cnt = 0; end
      else m_cnt = (m_cnt + 1) & 3;
    end else if (e_hold && e_mask != 0) m_rd = 0;
    m_cur = t;
    m_sq  = sleep;
    @(negedge clk);
    chk("rdata_en", rdata_en, int'(m_act && m_rd && !oe_n && !sleep));
    if (m_act) chk("burst_addr", burst_addr, m_cur);
    if (m_act && m_rd && !oe_n && !sleep) chk("rdata", rdata, mm[m_cur]);
  endtask

  task automatic pload(int a);
    idle(); sp_n = 0; addr = 8'(a); sc_n = 0; gw_n = 0; cyc();
  endtask
  task automatic cload(int a, logic g, logic be, logic [1:0] bw, logic [17:0] d);
    idle(); sc_n = 0; addr = 8'(a); gw_n = g; bwe_n = be; bw_n = bw; wdata = d; cyc();
  endtask
  task automatic advc();
    idle(); adv_n = 0; cyc();
  endtask
  task automatic waitc();
    idle(); cyc();
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    tag = "R1";
    chk("rdata_en after reset", rdata_en, 0);
    waitc();
    // fill every word with known data through global writes
    tag = "R6";
    for (int a = 0; a < 256; a++) cload(a, 0, 1, 2'b11, 18'(a * 1237 + 7));
    tag = "R12";
    cload(5, 1, 1, 2'b11, '0);
    tag = "R2";
    idle(); sp_n = 0; sc_n = 0; gw_n = 0; addr = 8'd10; wdata = 18'h3ffff; cyc();
    waitc();
    tag = "R3";
    idle(); sp_n = 0; ce_n = 1; addr = 8'd99; cyc();
    advc();
    tag = "R4";
    cload(20, 1, 0, 2'b10, 18'h2aaaa);
    cload(20, 1, 1, 2'b11, '0);
    idle(); sc_n = 0; ce_n = 1; cyc();
    advc();
    tag = "R5";
    idle(); sc_n = 0; addr = 8'd30; ce2 = 0; cyc();
    cload(31, 1, 1, 2'b11, '0);
    idle(); ce2 = 0; ce2_n = 1; cyc();
    idle(); sc_n = 0; addr = 8'd32; ce2_n = 1; cyc();
    tag = "R6";
    cload(50, 1, 0, 2'b01, 18'h1ffff);
    cload(51, 1, 0, 2'b00, 18'h12345);
    cload(52, 0, 0, 2'b11, 18'h0abcd);
    cload(53, 1, 0, 2'b11, 18'h3ffff);
    for (int a = 50; a < 54; a++) cload(a, 1, 1, 2'b11, '0);
    tag = "R7";
    pload(40);
    idle(); gw_n = 0; wdata = 18'h15555; cyc();
    waitc();
    pload(40);
    tag = "R8";
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++) begin
        lin = m[0];
        pload(64 + s);
        for (int k = 0; k < 5; k++) advc();
      end
    lin = 1;
    tag = "R9";
    pload(70);
    advc(); waitc(); waitc(); advc();
    pload(90); advc();
    cload(100, 1, 1, 2'b11, '0); advc();
    tag = "R10";
    idle(); oe_n = 1; cyc();
    waitc();
    cload(110, 0, 1, 2'b11, 18'h00f0f);
    waitc(); waitc();
    advc();
    idle(); sp_n = 0; addr = 8'd110; oe_n = 1; cyc();
    waitc();
    tag = "R11";
    pload(120);
    idle(); sleep = 1; sc_n = 0; gw_n = 0; addr = 8'd120; wdata = 18'h0; cyc();
    idle(); sleep = 1; advc();
    idle(); sc_n = 0; gw_n = 0; addr = 8'd121; wdata = 18'h0; cyc();
    cload(121, 1, 1, 2'b11, '0);
    pload(120);
    tag = "R12";
    cload(130, 0, 1, 2'b11, 18'h24680);
    pload(130);
    advc(); advc();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule